// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a small data cache placed between a processor port that addresses single words and a slower main-memory port that moves one word per beat. Each main-memory block has exactly one frame it may occupy, chosen by the index bits of its address. A frame keeps a stored tag, a valid flag and a dirty flag, plus the data words of the block. A single tag comparison, qualified by the valid flag, decides hit or miss.

Read hits and write hits complete in the cycle they are presented. A write hit changes only the cached copy and marks the frame dirty. A read miss first returns a dirty victim to memory, if there is one, and then loads the whole block, starting at word 0. The requested word goes to the processor in the beat in which it arrives from memory, and the rest of the block keeps loading after that. A write miss does not claim a frame. It sends the single word straight to memory.

Both ports use valid/ready. The processor holds `cpu_valid` and its request fields steady until it sees `cpu_ready`. The cache raises `cpu_ready` for exactly one cycle per request, and it accepts nothing new until any block transfer in progress has finished. On the memory side, a beat completes when `mem_valid` and `mem_ready` are both high. The cache holds every memory request field steady while `mem_ready` is low, and it samples `mem_rdata` in the completing cycle.

Top module: `wb_dm_cache`

## Requirements
- R1: After reset every frame is invalid: the cache raises neither `cpu_ready` nor `mem_valid` while idle, and the first read of any block is a miss.
- R2: The word address splits into tag = bits [6:5], index = bits [4:3] and offset = bits [2:0]. A block may live only in the frame given by its index. A request hits when that frame is valid and its stored tag equals the address tag, and a hit raises `cpu_ready` in the same cycle as `cpu_valid`.
- R3: A read hit returns the cached word on `cpu_rdata` and produces no memory beat.
- R4: A write hit updates only the cached word, produces no memory beat and marks the frame dirty.
- R5: A read miss loads the block with 8 read beats at addresses {tag, index, 0} up to {tag, index, 7}, in ascending order.
- R6: If the victim frame is valid and dirty, 8 write beats send the victim's words 0 to 7, with their cached values, to {victim tag, index, 0..7} before the first read beat.
- R7: On a read miss, `cpu_ready` is high with the requested word on `cpu_rdata` exactly in the cycle of the read beat whose offset equals the request offset.
- R8: A write miss produces one write beat of `cpu_wdata` to the request address and raises `cpu_ready` in that beat's completing cycle. The frame's tag, flags and data stay unchanged.
- R9: A freshly loaded block is clean: replacing it before any write to it causes no write beats.
- R10: While a block transfer is in progress, `cpu_ready` stays low for any new request. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_write` and `mem_wdata` do not change in the next cycle.
- R11: `cpu_ready` is raised only while `cpu_valid` is high, and only once per request. A memory beat completes only in a cycle with `mem_valid` and `mem_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_write | input | 1 | 1 = write request, 0 = read request |
| cpu_addr | input | 7 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid when `cpu_ready` is high for a read |
| mem_valid | output | 1 | Memory beat requested |
| mem_ready | input | 1 | Memory accepts or answers the beat this cycle |
| mem_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 7 | Memory word address of the beat |
| mem_wdata | output | 16 | Data of a write beat |
| mem_rdata | input | 16 | Data of a read beat, sampled when `mem_ready` is high |

## Verification
The assertions check the following on every cycle:
- A stalled memory request stays frozen.
- `cpu_ready` never appears without `cpu_valid`, and from the idle state only on a hit.
- The memory port stays quiet while idle.
- The last write-back beat always hands over to a fill starting at word 0.
- A loaded frame is valid and clean, and a write hit leaves its frame dirty.

Only the bench's scenarios can show that the returned data equals the last value written, that the beats come in the expected order with the expected victim contents, that the load-through word arrives on the right beat, and that a write miss leaves the resident block in place. The bench shows these by comparing every beat against a reference model, both with memory always ready and with memory stalling.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_AROUND
  } cache_state_e;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int TAG_W = 2,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_set,
  input  logic [IDX_W-1:0] dirty_idx
);

  localparam int FRAMES = 1 << IDX_W;

  logic [FRAMES-1:0] vld_q;
  logic [FRAMES-1:0] dty_q;
  logic [TAG_W-1:0]  tag_q [FRAMES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
      for (int f = 0; f < FRAMES; f++) tag_q[f] <= '0;
    end else begin
      for (int f = 0; f < FRAMES; f++) begin
        if (fill_we && fill_idx == IDX_W'(f)) begin
          vld_q[f] <= 1'b1;
          dty_q[f] <= 1'b0;
          tag_q[f] <= fill_tag;
        end else if (dirty_set && dirty_idx == IDX_W'(f)) begin
          dty_q[f] <= 1'b1;
        end
      end
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_dirty = dty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

  for (genvar g = 0; g < FRAMES; g++) begin : g_frame_chk
    // R9: a block that has just been loaded is valid and clean
    a_r9_fill_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_we && fill_idx == IDX_W'(g)) |=> (vld_q[g] && !dty_q[g]));
    // R4: a write hit leaves its frame dirty
    a_r4_dirty_mark: assert property (@(posedge clk) disable iff (!rst_n)
      (dirty_set && dirty_idx == IDX_W'(g)) |=> dty_q[g]);
  end

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int DEPTH = 1 << (IDX_W + OFF_W);

  logic [DATA_W-1:0] word_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[{wr_idx, wr_off}] <= wr_data;
  end

  assign rd_data = word_q[{rd_idx, rd_off}];

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_valid,
  output logic                    cpu_ready,
  input  logic                    cpu_write,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic                    mem_write,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic [IDX_W-1:0]        lk_idx,
  input  logic                    lk_valid,
  input  logic                    lk_dirty,
  input  logic [ADDR_W-IDX_W-OFF_W-1:0] lk_tag,
  output logic                    fill_we,
  output logic [IDX_W-1:0]        fill_idx,
  output logic [ADDR_W-IDX_W-OFF_W-1:0] fill_tag,
  output logic                    dirty_set,
  output logic [IDX_W-1:0]        dirty_idx,
  output logic [IDX_W-1:0]        d_rd_idx,
  output logic [OFF_W-1:0]        d_rd_off,
  input  logic [DATA_W-1:0]       d_rd_data,
  output logic                    d_wr_en,
  output logic [IDX_W-1:0]        d_wr_idx,
  output logic [OFF_W-1:0]        d_wr_off,
  output logic [DATA_W-1:0]       d_wr_data
);

  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_BEAT = '1;

  cache_state_e state_q;
  logic [OFF_W-1:0]  beat_q;
  logic [TAG_W-1:0]  lat_tag_q, vic_tag_q;
  logic [IDX_W-1:0]  lat_idx_q;
  logic [OFF_W-1:0]  lat_off_q;
  logic [DATA_W-1:0] lat_wdata_q;

  logic [TAG_W-1:0] c_tag;
  logic [IDX_W-1:0] c_idx;
  logic [OFF_W-1:0] c_off;
  logic             hit;

  assign c_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign c_idx = cpu_addr[OFF_W +: IDX_W];
  assign c_off = cpu_addr[OFF_W-1:0];
  assign lk_idx = c_idx;
  assign hit    = lk_valid && (lk_tag == c_tag);

  always_comb begin
    cpu_ready = 1'b0;
    cpu_rdata = d_rd_data;
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = {lat_tag_q, lat_idx_q, beat_q};
    mem_wdata = '0;
    d_rd_idx  = c_idx;
    d_rd_off  = c_off;
    d_wr_en   = 1'b0;
    d_wr_idx  = lat_idx_q;
    d_wr_off  = beat_q;
    d_wr_data = mem_rdata;
    fill_we   = 1'b0;
    fill_idx  = lat_idx_q;
    fill_tag  = lat_tag_q;
    dirty_set = 1'b0;
    dirty_idx = c_idx;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_valid && hit) begin
          cpu_ready = 1'b1;
          if (cpu_write) begin
            d_wr_en   = 1'b1;
            d_wr_idx  = c_idx;
            d_wr_off  = c_off;
            d_wr_data = cpu_wdata;
            dirty_set = 1'b1;
          end
        end
      end
      ST_EVICT: begin
        d_rd_idx  = lat_idx_q;
        d_rd_off  = beat_q;
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = {vic_tag_q, lat_idx_q, beat_q};
        mem_wdata = d_rd_data;
      end
      ST_FILL: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          d_wr_en = 1'b1;
          if (beat_q == lat_off_q) begin
            cpu_ready = 1'b1;
            cpu_rdata = mem_rdata;
          end
          if (beat_q == LAST_BEAT) fill_we = 1'b1;
        end
      end
      ST_AROUND: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = {lat_tag_q, lat_idx_q, lat_off_q};
        mem_wdata = lat_wdata_q;
        cpu_ready = mem_ready;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      beat_q      <= '0;
      lat_tag_q   <= '0;
      vic_tag_q   <= '0;
      lat_idx_q   <= '0;
      lat_off_q   <= '0;
      lat_wdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_valid && !hit) begin
            lat_tag_q   <= c_tag;
            lat_idx_q   <= c_idx;
            lat_off_q   <= c_off;
            lat_wdata_q <= cpu_wdata;
            vic_tag_q   <= lk_tag;
            beat_q      <= '0;
            if (cpu_write)                state_q <= ST_AROUND;
            else if (lk_valid && lk_dirty) state_q <= ST_EVICT;
            else                          state_q <= ST_FILL;
          end
        end
        ST_EVICT: begin
          if (mem_ready) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == LAST_BEAT) state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ready) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == LAST_BEAT) state_q <= ST_IDLE;
          end
        end
        ST_AROUND: begin
          if (mem_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: a stalled memory request holds all of its fields
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_write) && $stable(mem_wdata)));
  // R11: completion is only signalled for a presented request
  a_r11_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);
  // R2: from the idle state the processor is released only on a hit
  a_r2_idle_ready_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && state_q == ST_IDLE) |-> hit);
  // R3: no memory traffic while idle, so hits never touch memory
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !mem_valid);
  // R6: the last write-back beat hands over to a fill from word 0
  a_r6_evict_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVICT && mem_ready && beat_q == LAST_BEAT) |=>
      (state_q == ST_FILL && beat_q == '0));

endmodule

// File: rtl/wb_dm_cache.sv
module wb_dm_cache #(
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]  lk_idx, fill_idx, dirty_idx, d_rd_idx, d_wr_idx;
  logic              lk_valid, lk_dirty, fill_we, dirty_set, d_wr_en;
  logic [TAG_W-1:0]  lk_tag, fill_tag;
  logic [OFF_W-1:0]  d_rd_off, d_wr_off;
  logic [DATA_W-1:0] d_rd_data, d_wr_data;

  cache_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_valid(lk_valid), .rd_dirty(lk_dirty), .rd_tag(lk_tag),
    .fill_we(fill_we), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .dirty_set(dirty_set), .dirty_idx(dirty_idx)
  );

  cache_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
    .clk(clk),
    .rd_idx(d_rd_idx), .rd_off(d_rd_off), .rd_data(d_rd_data),
    .wr_en(d_wr_en), .wr_idx(d_wr_idx), .wr_off(d_wr_off), .wr_data(d_wr_data)
  );

  cache_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_dirty(lk_dirty), .lk_tag(lk_tag),
    .fill_we(fill_we), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .dirty_set(dirty_set), .dirty_idx(dirty_idx),
    .d_rd_idx(d_rd_idx), .d_rd_off(d_rd_off), .d_rd_data(d_rd_data),
    .d_wr_en(d_wr_en), .d_wr_idx(d_wr_idx), .d_wr_off(d_wr_off), .d_wr_data(d_wr_data)
  );

endmodule

// File: tb/wb_dm_cache_bench.sv
module wb_dm_cache_bench;

  localparam int CLK_P = 10;

  typedef struct {
    bit          wr;
    int          addr;
    logic [15:0] data;
    int          kind;   // 0 write-back, 1 fill, 2 write-around
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_write = 1'b0;
  logic [6:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        mem_ready = 1'b0;
  logic        cpu_ready, mem_valid, mem_write;
  logic [15:0] cpu_rdata, mem_wdata, mem_rdata;
  logic [6:0]  mem_addr;

  wb_dm_cache u_wb_dm_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int failures = 0;

  logic [15:0] mem_model [128];
  logic [15:0] golden [128];
  bit          fv [4];
  int          ftag [4];
  bit          fd [4];
  beat_t       q[$];

  bit          active = 0, served = 0;
  int          kind = 0, req_addr = 0, idle_wait = 0;
  logic [15:0] exp_rdata = '0;
  int          n_rd = 0, n_wr = 0, rcnt = 0;
  bit          stall_mode = 0;
  bit          prev_stall = 0, prev_write = 0;
  logic [6:0]  prev_addr = '0;
  logic [15:0] prev_wdata = '0;

  assign mem_rdata = mem_model[mem_addr];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string kind_req(int k);
    case (k)
      0: return "R6";
      1: return "R5";
      default: return "R8";
    endcase
  endfunction

  always @(negedge clk) begin
    mem_ready = stall_mode ? (rcnt % 3 == 2) : 1'b1;
    rcnt++;
  end

  // sampled one time unit before each rising edge
  always @(negedge clk) begin
    #(CLK_P/2 - 1);
    if (rst_n) begin
      if (prev_stall)
        check(mem_valid && mem_addr == prev_addr && mem_write == prev_write &&
              (!mem_write || mem_wdata == prev_wdata), "R10", "stalled beat held",
              int'(mem_addr), int'(prev_addr));
      prev_stall = mem_valid && !mem_ready;
      prev_addr  = mem_addr;
      prev_write = mem_write;
      prev_wdata = mem_wdata;

      if (cpu_ready) begin
        if (!active || served || !cpu_valid) begin
          check(0, "R11", "ready without pending request", 1, 0);
        end else begin
          case (kind)
            0: begin
              check(idle_wait == 0, "R2", "hit ready latency", idle_wait, 0);
              check(q.size() == 0, "R10", "accepted during transfer", q.size(), 0);
              check(cpu_rdata == exp_rdata, "R3", "read hit data", int'(cpu_rdata), int'(exp_rdata));
            end
            1: begin
              check(idle_wait == 0, "R4", "write hit ready latency", idle_wait, 0);
              check(q.size() == 0, "R10", "accepted during transfer", q.size(), 0);
            end
            2: begin
              check(mem_valid && mem_ready && !mem_write && int'(mem_addr) == req_addr,
                    "R7", "ready on matching fill beat", int'(mem_addr), req_addr);
              check(cpu_rdata == exp_rdata, "R7", "load-through data", int'(cpu_rdata), int'(exp_rdata));
            end
            default: begin
              check(mem_valid && mem_ready && mem_write && int'(mem_addr) == req_addr && q.size() == 1,
                    "R8", "write miss ready with its beat", int'(mem_addr), req_addr);
            end
          endcase
        end
        served = 1;
      end else if (active && !served && q.size() == 0) begin
        idle_wait++;
      end

      if (mem_valid && mem_ready) begin
        if (mem_write) n_wr++; else n_rd++;
        if (q.size() == 0) begin
          check(0, "R11", "unexpected memory beat", int'(mem_addr), -1);
        end else begin
          beat_t b;
          b = q.pop_front();
          check(mem_write == b.wr && int'(mem_addr) == b.addr &&
                (!b.wr || mem_wdata == b.data), kind_req(b.kind), "memory beat",
                int'(mem_addr) + (mem_write ? 1000 : 0) + (int'(mem_wdata) << 11),
                b.addr + (b.wr ? 1000 : 0) + (int'(b.data) << 11));
        end
        if (mem_write) mem_model[mem_addr] = mem_wdata;
      end
    end
  end

  task automatic issue(bit wr, int a, logic [15:0] d);
    int idx, tg, t;
    beat_t b;
    @(negedge clk);
    idx = (a >> 3) & 3;
    tg  = a >> 5;
    if (wr) begin
      if (fv[idx] && ftag[idx] == tg) begin
        kind = 1;
        fd[idx] = 1;
      end else begin
        kind = 3;
        b.wr = 1; b.addr = a; b.data = d; b.kind = 2;
        q.push_back(b);
      end
      golden[a] = d;
    end else begin
      exp_rdata = golden[a];
      if (fv[idx] && ftag[idx] == tg) begin
        kind = 0;
      end else begin
        kind = 2;
        if (fv[idx] && fd[idx]) begin
          for (int w = 0; w < 8; w++) begin
            b.wr = 1; b.addr = (ftag[idx] << 5) | (idx << 3) | w;
            b.data = golden[b.addr]; b.kind = 0;
            q.push_back(b);
          end
        end
        for (int w = 0; w < 8; w++) begin
          b.wr = 0; b.addr = (tg << 5) | (idx << 3) | w; b.data = '0; b.kind = 1;
          q.push_back(b);
        end
        fv[idx] = 1; ftag[idx] = tg; fd[idx] = 0;
      end
    end
    req_addr  = a;
    idle_wait = 0;
    served    = 0;
    active    = 1;
    cpu_valid = 1'b1;
    cpu_write = wr;
    cpu_addr  = 7'(a);
    cpu_wdata = d;
    t = 0;
    while (!served && t < 500) begin
      @(posedge clk);
      t++;
    end
    if (!served) check(0, "R11", "request never completed", t, 500);
  endtask

  task automatic drain();
    int t;
    @(negedge clk);
    cpu_valid = 1'b0;
    active    = 0;
    t = 0;
    while (q.size() != 0 && t < 500) begin
      @(posedge clk);
      t++;
    end
    check(q.size() == 0, "R11", "outstanding beats after drain", q.size(), 0);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    check(0, "R11", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base_rd, base_wr;
    logic [15:0] lfsr;
    for (int i = 0; i < 128; i++) begin
      mem_model[i] = 16'(i * 37 + 5);
      golden[i]    = mem_model[i];
    end
    for (int i = 0; i < 4; i++) begin fv[i] = 0; fd[i] = 0; ftag[i] = 0; end

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #(CLK_P/2 - 1);
    // R1: nothing happens from an empty, idle cache
    check(cpu_ready == 1'b0, "R1", "idle cpu_ready after reset", int'(cpu_ready), 0);
    check(mem_valid == 1'b0, "R1", "idle mem_valid after reset", int'(mem_valid), 0);

    // R1 R5 R7: first read misses, load-through at offset 3
    base_rd = n_rd;
    issue(0, 7'h0B, 0);
    drain();
    check(n_rd - base_rd == 8, "R1", "first read fills a block", n_rd - base_rd, 8);

    // R2 R3: hits in the same block
    issue(0, 7'h0F, 0);
    issue(0, 7'h08, 0);
    // R4: write hit, then read it back
    issue(1, 7'h0A, 16'hBEEF);
    issue(0, 7'h0A, 0);
    drain();

    // R6: dirty victim written back before the fill
    base_wr = n_wr;
    issue(0, 7'h2A, 0);
    drain();
    check(n_wr - base_wr == 8, "R6", "dirty victim write-back count", n_wr - base_wr, 8);

    // R9: the block just loaded is clean; replacing it writes nothing
    base_wr = n_wr;
    issue(0, 7'h0A, 0);
    drain();
    check(n_wr - base_wr == 0, "R9", "clean victim causes no writes", n_wr - base_wr, 0);

    // R8: write miss goes around the cache; then read misses
    issue(1, 7'h50, 16'h1234);
    issue(0, 7'h50, 0);
    drain();
    issue(1, 7'h0C, 16'h5A5A);
    issue(1, 7'h6C, 16'hA5A5);
    base_rd = n_rd;
    issue(0, 7'h0C, 0);
    drain();
    check(n_rd - base_rd == 0, "R8", "write miss did not allocate", n_rd - base_rd, 0);

    // R10 R11: same patterns with a stalling memory, offsets 0 and 7
    stall_mode = 1;
    issue(1, 7'h0D, 16'h7777);
    issue(0, 7'h7F, 0);
    issue(0, 7'h2D, 0);
    issue(0, 7'h38, 0);
    issue(0, 7'h57, 0);
    issue(0, 7'h0D, 0);
    drain();

    // mixed traffic in both memory modes
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      stall_mode = (n >= 200);
      issue(lfsr[0] & lfsr[5], int'(lfsr[11:5]) & 127, lfsr ^ 16'h3C3C);
    end
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule